// File: doc/BRIEF.md
# Tail-Parity Syndrome Decoder and Single-Bit Corrector

This block receives a protected word in which all the check bits sit above the payload, as `{checks, payload}`. It recomputes every parity check, each one including its received check bit, and so forms a syndrome. The low part of the syndrome names the failing payload position directly. One extra top check covers only the check field, and it tells an upset in the check bits apart from an upset in the payload. A single flipped payload bit is inverted back. The recovered payload leaves one clock after the input strobe, together with flags that classify what was found.

The payload width `N` is a parameter. The intended sizes are 7 bits (4 check bits, 11-bit word) and 31 bits (6 check bits, 37-bit word). Any other width also elaborates. When `N` is not of the form 2^K-1, some syndrome values name positions that do not exist. Those syndromes are reported as uncorrectable. The block has no double-error detection and never corrects more than one bit.

Top module: `tailpar_decoder`

## Requirements
- R1: With K = ceil(log2(N+1)), the word is N+K+1 bits wide. Payload position p (1..N) is word bit p-1. Check bit j (0..K-1) is word bit N+j, and it gives even parity over itself and every payload position p whose binary bit j is 1. The top bit, word bit N+K, gives even parity over the whole check field N..N+K.
- R2: When every check passes, `dataOut` equals the received payload, and `errDetected`, `redundancyErr`, `uncorrectable` and `errPos` are all 0.
- R3: When the top check passes and the low syndrome s satisfies 1 <= s <= N, payload bit s-1 is inverted. In that case `errPos` = s, `errDetected` = 1, and `redundancyErr` = `uncorrectable` = 0.
- R4: When the top check fails, the payload passes unchanged, with `errDetected` = 1, `redundancyErr` = 1, `uncorrectable` = 0 and `errPos` = 0.
- R5: When the top check passes and the low syndrome exceeds N, the payload passes unchanged, with `errDetected` = 1, `uncorrectable` = 1, `redundancyErr` = 0 and `errPos` = 0.
- R6: `outValid` is `inValid` delayed by one clock. In a cycle where `inValid` is 0, `dataOut`, `errPos` and the three flags keep their values.
- R7: A synchronous reset clears `outValid`, `dataOut`, `errPos` and the three flags to 0.
- R8: For N = 7, the received word 11'b01100011001 yields syndrome 0110 and `errPos` = 6, and `dataOut` = 7'b0111001.
- R9: For N = 31, the payload 31'h3728766A is recovered intact whichever single bit of its 37-bit word is flipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies `codeIn` in this cycle |
| codeIn | input | N+K+1 | Received word, check field above payload |
| outValid | output | 1 | Outputs below belong to the word taken one cycle earlier |
| dataOut | output | N | Recovered payload |
| errDetected | output | 1 | At least one check failed |
| errPos | output | K | Payload position that was inverted, 0 if none |
| redundancyErr | output | 1 | The failure lies in the check field |
| uncorrectable | output | 1 | Syndrome names a position beyond N |

## Verification
Every check bit is flipped in turn. A decoder that ignores the top check would then invert a payload bit that was never wrong, and the clean-payload comparison catches this. Every payload position is flipped on both the 7-bit and the 31-bit builds, so an off-by-one in the position decode shows up as the wrong bit inverted and a wrong `errPos`. A 12-bit build receives double errors whose syndromes lie beyond the payload, where a decoder lacking the range test would corrupt a bit or index out of range. Idle cycles with a changing input show whether the outputs leak through without the strobe.

// File: rtl/tailpar_pkg.sv
package tailpar_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic capture;   // load the output registers this cycle
    logic flipData;  // invert the payload bit named by the low syndrome
  } tp_strobe_t;

  // Number of position-covering checks for an n-bit payload.
  function automatic int checkCount(input int n);
    int k;
    k = 0;
    while ((1 << k) < (n + 1)) k++;
    return k;
  endfunction

endpackage

// File: rtl/tailpar_datapath.sv
module tailpar_datapath
  import tailpar_pkg::*;
#(
  parameter int N = 7,
  parameter int K = 3,
  parameter int W = N + K + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] codeIn,
  input  tp_strobe_t   strobe,
  output logic [K:0]   synd,
  output logic [N-1:0] dataOut,
  output logic [K-1:0] errPos
);

  logic [N-1:0] payload;
  logic [K:0]   checkField;
  logic [N-1:0] flipVec;

  assign payload    = codeIn[N-1:0];
  assign checkField = codeIn[W-1:N];

  // Payload positions whose binary index has bit k set.
  function automatic logic [N-1:0] coverMask(input int k);
    logic [N-1:0] m;
    for (int p = 1; p <= N; p++) m[p-1] = ((p >> k) & 1) == 1;
    return m;
  endfunction

  // Position-covering checks, each including its own received check bit.
  for (genvar k = 0; k < K; k++) begin : g_check
    localparam logic [N-1:0] MASK = coverMask(k);
    assign synd[k] = ^(payload & MASK) ^ checkField[k];
  end

  // Top check spans the check field only.
  assign synd[K] = ^checkField;

  // One-hot position decode of the low syndrome.
  for (genvar p = 1; p <= N; p++) begin : g_flip
    assign flipVec[p-1] = strobe.flipData && (synd[K-1:0] == K'(p));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut <= '0;
      errPos  <= '0;
    end else if (strobe.capture) begin
      dataOut <= payload ^ flipVec;
      errPos  <= strobe.flipData ? synd[K-1:0] : '0;
    end
  end

endmodule

// File: rtl/tailpar_control.sv
module tailpar_control
  import tailpar_pkg::*;
#(
  parameter int N = 7,
  parameter int K = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [K:0] synd,
  output tp_strobe_t strobe,
  output logic       outValid,
  output logic       errDetected,
  output logic       redundancyErr,
  output logic       uncorrectable
);

  localparam logic [K-1:0] LAST_POS = K'(N);

  logic lowNonZero;
  logic topFail;
  logic beyondLast;
  logic anyFail;

  assign lowNonZero = |synd[K-1:0];
  assign topFail    = synd[K];
  assign beyondLast = !topFail && (synd[K-1:0] > LAST_POS);
  assign anyFail    = lowNonZero || topFail;

  always_comb begin
    strobe          = '0;
    strobe.capture  = inValid;
    strobe.flipData = !topFail && lowNonZero && !beyondLast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid      <= 1'b0;
      errDetected   <= 1'b0;
      redundancyErr <= 1'b0;
      uncorrectable <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        errDetected   <= anyFail;
        redundancyErr <= topFail;
        uncorrectable <= beyondLast;
      end
    end
  end

endmodule

// File: rtl/tailpar_decoder.sv
module tailpar_decoder
  import tailpar_pkg::*;
#(
  parameter  int N = 7,
  localparam int K = checkCount(N),
  localparam int W = N + K + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [W-1:0] codeIn,
  output logic         outValid,
  output logic [N-1:0] dataOut,
  output logic         errDetected,
  output logic [K-1:0] errPos,
  output logic         redundancyErr,
  output logic         uncorrectable
);

  tp_strobe_t strobe;
  logic [K:0] synd;

  tailpar_datapath #(.N(N), .K(K), .W(W)) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .codeIn  (codeIn),
    .strobe  (strobe),
    .synd    (synd),
    .dataOut (dataOut),
    .errPos  (errPos)
  );

  tailpar_control #(.N(N), .K(K)) u_control (
    .clk           (clk),
    .rst           (rst),
    .inValid       (inValid),
    .synd          (synd),
    .strobe        (strobe),
    .outValid      (outValid),
    .errDetected   (errDetected),
    .redundancyErr (redundancyErr),
    .uncorrectable (uncorrectable)
  );

endmodule

// File: rtl/tailpar_checker.sv
module tailpar_checker #(
  parameter int N = 7,
  parameter int K = 3,
  parameter int W = N + K + 1
) (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic [W-1:0] codeIn,
  input logic         outValid,
  input logic [N-1:0] dataOut,
  input logic         errDetected,
  input logic [K-1:0] errPos,
  input logic         redundancyErr,
  input logic         uncorrectable
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!outValid && dataOut == '0 && errPos == '0 && !errDetected && !redundancyErr && !uncorrectable)); // R7

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R6

  AST_IDLE_DROP: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(dataOut) && $stable(errPos) && $stable(errDetected)
                  && $stable(redundancyErr) && $stable(uncorrectable))); // R6

  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
    (outValid && !errDetected) |-> (dataOut == $past(codeIn[N-1:0]) && errPos == '0)); // R2

  AST_CHECK_FIELD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (outValid && redundancyErr) |-> (errDetected && errPos == '0 && dataOut == $past(codeIn[N-1:0]))); // R4

  AST_UNCORR_KEEP: assert property (@(posedge clk) disable iff (rst)
    (outValid && uncorrectable) |-> (errDetected && errPos == '0 && dataOut == $past(codeIn[N-1:0]))); // R5

  AST_CORR_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (outValid && |errPos) |-> (errDetected && $countones(dataOut ^ $past(codeIn[N-1:0])) == 1)); // R3

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $onehot0({redundancyErr, uncorrectable, |errPos})); // R3

endmodule

bind tailpar_decoder tailpar_checker #(.N(N), .K(K), .W(W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .inValid       (inValid),
  .codeIn        (codeIn),
  .outValid      (outValid),
  .dataOut       (dataOut),
  .errDetected   (errDetected),
  .errPos        (errPos),
  .redundancyErr (redundancyErr),
  .uncorrectable (uncorrectable)
);

// File: tb/tailpar_decoder_tb.sv
module tailpar_decoder_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;

  // Build A: N = 7
  logic        vA = 1'b0;
  logic [10:0] cA = '0;
  logic        ovA, eA, rdA, uA;
  logic [6:0]  dA;
  logic [2:0]  pA;

  // Build B: N = 31
  logic        vB = 1'b0;
  logic [36:0] cB = '0;
  logic        ovB, eB, rdB, uB;
  logic [30:0] dB;
  logic [4:0]  pB;

  // Build C: N = 12
  logic        vC = 1'b0;
  logic [16:0] cC = '0;
  logic        ovC, eC, rdC, uC;
  logic [11:0] dC;
  logic [3:0]  pC;

  tailpar_decoder #(.N(7)) u_dut (
    .clk(clk), .rst(rst), .inValid(vA), .codeIn(cA), .outValid(ovA), .dataOut(dA),
    .errDetected(eA), .errPos(pA), .redundancyErr(rdA), .uncorrectable(uA));

  tailpar_decoder #(.N(31)) u_dut31 (
    .clk(clk), .rst(rst), .inValid(vB), .codeIn(cB), .outValid(ovB), .dataOut(dB),
    .errDetected(eB), .errPos(pB), .redundancyErr(rdB), .uncorrectable(uB));

  tailpar_decoder #(.N(12)) u_dut12 (
    .clk(clk), .rst(rst), .inValid(vC), .codeIn(cC), .outValid(ovC), .dataOut(dC),
    .errDetected(eC), .errPos(pC), .redundancyErr(rdC), .uncorrectable(uC));

  // Encoder built from R1.
  function automatic int checksFor(input int n);
    int k;
    k = 0;
    while ((1 << k) < (n + 1)) k++;
    return k;
  endfunction

  function automatic logic [63:0] encodeWord(input int n, input logic [63:0] d);
    int k;
    logic [63:0] w;
    logic par, top;
    k = checksFor(n);
    w = '0;
    top = 1'b0;
    for (int p = 1; p <= n; p++) w[p-1] = d[p-1];
    for (int j = 0; j < k; j++) begin
      par = 1'b0;
      for (int p = 1; p <= n; p++) if (((p >> j) & 1) == 1) par ^= d[p-1];
      w[n+j] = par;
      top ^= par;
    end
    w[n+k] = top;
    return w;
  endfunction

  task automatic checkVal(input string req, input string what,
                          input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // flags are {errDetected, redundancyErr, uncorrectable}
  task automatic checkOut(input string req, input string what,
                          input logic gValid, input logic [63:0] gData, input logic [63:0] gPos,
                          input logic [2:0] gFlags,
                          input logic [63:0] eData, input logic [63:0] ePos, input logic [2:0] eFlags);
    nChecks++;
    if (gValid !== 1'b1 || gData !== eData || gPos !== ePos || gFlags !== eFlags) begin
      nFail++;
      $display("FAIL %s %s: actual valid=%b data=%0h pos=%0d flags=%b expected valid=1 data=%0h pos=%0d flags=%b",
               req, what, gValid, gData, gPos, gFlags, eData, ePos, eFlags);
    end
  endtask

  task automatic driveA(input logic [63:0] w);
    @(negedge clk); cA = w[10:0]; vA = 1'b1;
    @(negedge clk); vA = 1'b0;
  endtask

  task automatic driveB(input logic [63:0] w);
    @(negedge clk); cB = w[36:0]; vB = 1'b1;
    @(negedge clk); vB = 1'b0;
  endtask

  task automatic driveC(input logic [63:0] w);
    @(negedge clk); cC = w[16:0]; vC = 1'b1;
    @(negedge clk); vC = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  // ---------------- scenarios ----------------

  task automatic testResetState();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checkVal("R7", "A outputs in reset", {ovA, eA, rdA, uA, 3'(pA), dA}, 64'd0);
    checkVal("R7", "B outputs in reset", {ovB, eB, rdB, uB, 5'(pB), dB}, 64'd0);
    checkVal("R7", "C outputs in reset", {ovC, eC, rdC, uC, 4'(pC), dC}, 64'd0);
    rst = 1'b0;
  endtask

  task automatic testCleanSweep();
    for (int d = 0; d < 128; d++) begin
      driveA(encodeWord(7, 64'(d)));
      checkOut("R2", $sformatf("clean payload %0h", d), ovA, 64'(dA), 64'(pA), {eA, rdA, uA},
               64'(d), 64'd0, 3'b000);
    end
  endtask

  task automatic testKnownWords();
    driveA(64'(11'b01100111001));
    checkOut("R1", "clean known word", ovA, 64'(dA), 64'(pA), {eA, rdA, uA},
             64'(7'b0111001), 64'd0, 3'b000);
    driveA(64'(11'b01100011001));
    checkOut("R8", "position 6 upset", ovA, 64'(dA), 64'(pA), {eA, rdA, uA},
             64'(7'b0111001), 64'd6, 3'b100);
  endtask

  task automatic testPayloadFlips();
    logic [6:0] pats [4] = '{7'h00, 7'h39, 7'h7F, 7'h52};
    for (int i = 0; i < 4; i++) begin
      for (int p = 1; p <= 7; p++) begin
        logic [63:0] w;
        w = encodeWord(7, 64'(pats[i]));
        w[p-1] = ~w[p-1];
        driveA(w);
        checkOut("R3", $sformatf("payload %0h flip pos %0d", pats[i], p), ovA, 64'(dA), 64'(pA),
                 {eA, rdA, uA}, 64'(pats[i]), 64'(p), 3'b100);
      end
    end
  endtask

  task automatic testCheckFieldFlips();
    logic [6:0] pats [3] = '{7'h00, 7'h39, 7'h6B};
    for (int i = 0; i < 3; i++) begin
      for (int b = 7; b <= 10; b++) begin
        logic [63:0] w;
        w = encodeWord(7, 64'(pats[i]));
        w[b] = ~w[b];
        driveA(w);
        checkOut("R4", $sformatf("payload %0h flip word bit %0d", pats[i], b), ovA, 64'(dA), 64'(pA),
                 {eA, rdA, uA}, 64'(pats[i]), 64'd0, 3'b110);
      end
    end
  endtask

  task automatic testWide();
    logic [63:0] base;
    base = encodeWord(31, 64'h3728766A);
    driveB(base);
    checkOut("R9", "wide clean", ovB, 64'(dB), 64'(pB), {eB, rdB, uB},
             64'h3728766A, 64'd0, 3'b000);
    for (int b = 0; b < 37; b++) begin
      logic [63:0] w;
      w = base;
      w[b] = ~w[b];
      driveB(w);
      if (b < 31)
        checkOut("R9", $sformatf("wide flip bit %0d", b), ovB, 64'(dB), 64'(pB), {eB, rdB, uB},
                 64'h3728766A, 64'(b + 1), 3'b100);
      else
        checkOut("R9", $sformatf("wide flip check bit %0d", b), ovB, 64'(dB), 64'(pB), {eB, rdB, uB},
                 64'h3728766A, 64'd0, 3'b110);
    end
  endtask

  task automatic testOutOfRange();
    int pairA [4] = '{1, 4, 3, 5};
    int pairB [4] = '{12, 9, 12, 10};
    logic [63:0] base;
    base = encodeWord(12, 64'hA5C);
    // single upset at the last position is still in range
    begin
      logic [63:0] w;
      w = base;
      w[11] = ~w[11];
      driveC(w);
      checkOut("R3", "N=12 flip pos 12", ovC, 64'(dC), 64'(pC), {eC, rdC, uC},
               64'hA5C, 64'd12, 3'b100);
    end
    for (int i = 0; i < 4; i++) begin
      logic [63:0] w;
      w = base;
      w[pairA[i]-1] = ~w[pairA[i]-1];
      w[pairB[i]-1] = ~w[pairB[i]-1];
      driveC(w);
      checkOut("R5", $sformatf("N=12 double upset %0d,%0d", pairA[i], pairB[i]), ovC, 64'(dC), 64'(pC),
               {eC, rdC, uC}, 64'(w[11:0]), 64'd0, 3'b101);
    end
  endtask

  task automatic testLatencyHold();
    logic [63:0] w;
    w = encodeWord(7, 64'h2D);
    w[2] = ~w[2];
    @(negedge clk); cA = w[10:0]; vA = 1'b1;
    #1 checkVal("R6", "no output before edge", 64'(ovA), 64'd0);
    @(negedge clk); vA = 1'b0;
    checkOut("R6", "one-cycle latency", ovA, 64'(dA), 64'(pA), {eA, rdA, uA},
             64'h2D, 64'd3, 3'b100);
    cA = 11'h7FF;
    @(negedge clk);
    checkVal("R6", "valid drops when idle", 64'(ovA), 64'd0);
    checkVal("R6", "data held when idle", 64'(dA), 64'h2D);
    checkVal("R6", "position held when idle", 64'(pA), 64'd3);
    cA = 11'h155;
    @(negedge clk);
    checkVal("R6", "flags held when idle", 64'({eA, rdA, uA}), 64'(3'b100));
  endtask

  task automatic testMidReset();
    logic [63:0] w;
    w = encodeWord(7, 64'h7F);
    w[9] = ~w[9];
    driveA(w);
    checkOut("R4", "before reset", ovA, 64'(dA), 64'(pA), {eA, rdA, uA}, 64'h7F, 64'd0, 3'b110);
    rst = 1'b1;
    @(negedge clk);
    checkVal("R7", "A cleared by reset", {ovA, eA, rdA, uA, 3'(pA), dA}, 64'd0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    testResetState();
    testKnownWords();
    testCleanSweep();
    testPayloadFlips();
    testCheckFieldFlips();
    testWide();
    testOutOfRange();
    testLatencyHold();
    testMidReset();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule